// File: doc/BRIEF.md
# Programmable Address Window Decoder

This block holds a bank of address windows that software programs through a plain 32-bit register port. Each window is described by a base address, a power-of-two size given as a mask of low-order ones in 64 KB units, an 8-bit target attribute and an enable. A transaction address presented with a valid strobe is compared against every enabled window. One cycle later the block reports either a hit together with the attribute of the winning window, or a decode error.

The size field acts directly as a mask. Address bits 31:16 are compared with the window base only where the size field holds zeros, so no start/end arithmetic is needed. When windows overlap, the lowest-numbered window wins. Software is expected to write base, size and attribute with the enable clear, and then to set the enable in a separate write.

Top module: `addr_window_decoder`

## Requirements
- R1: A synchronous active-low reset clears every window register to zero, which leaves all windows disabled, and drives `dec_hit`, `dec_err` and `dec_attr` to zero.
- R2: The control register of a window decodes as follows: bit 0 is the enable, bits 15:8 are the target attribute and bits 23:16 are the size mask. All other bits read back as zero.
- R3: Window n occupies byte offset 8·n of the register space. Its control register is at +0 and its base register at +4. The base register keeps bits 31:16 of the written data, and its bits 15:0 read as zero. Address bits 1:0 are ignored.
- R4: An enabled window matches when the address and the base are equal on bits 31:16 at every position where the size field, placed at bits 23:16, holds a zero. A size of 0x00 covers 64 KB and a size of 0xFF covers 16 MB.
- R5: A window whose enable bit is clear never matches, whatever its base, size and attribute. Setting the enable in a later write makes the stored configuration take effect.
- R6: When more than one enabled window matches, the attribute of the lowest-numbered window is reported.
- R7: A valid address that matches no window gives `dec_err`=1, `dec_hit`=0 and `dec_attr`=0.
- R8: When `txn_valid` is low, the following cycle shows `dec_hit`=0, `dec_err`=0 and `dec_attr`=0.
- R9: Window slots at or above NUM_WIN (default 8) read as zero. Writes to these slots change neither read data nor decoding.
- R10: Decode outputs are registered: they reflect the address and valid present before the clock edge. A register write applies to decodes sampled at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW (8) | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| txn_valid | input | 1 | Transaction address valid |
| txn_addr | input | 32 | Transaction address to decode |
| dec_hit | output | 1 | Registered: an enabled window matched |
| dec_err | output | 1 | Registered: valid address matched no window |
| dec_attr | output | 8 | Registered: attribute of the winning window, zero otherwise |

## Verification
A corrupted size or base bit shows up within one cycle as a hit that moves across a window edge. For this reason the vectors probe the last address inside and the first address outside each window. A broken priority or enable path turns into the wrong attribute, or a hit where a miss was expected, on the next decode of an overlapping or disabled window. Register storage faults are visible at once through combinational read-back. Write-gating faults on absent slots are caught by reading them back and by decoding an address that only such a slot would claim.

// File: rtl/awd_pkg.sv
// Package: shared window configuration type and register image helpers.
// Assumes 32-bit register data and 32-bit transaction addresses.
package awd_pkg;

    localparam int DATA_W   = 32;
    localparam int ATTR_W   = 8;
    localparam int SIZE_W   = 8;
    localparam int BASE_W   = 16;
    localparam int SLOT_LSB = 3;   // 8-byte slot stride

    typedef struct packed {
        logic              en;
        logic [ATTR_W-1:0] attr;
        logic [SIZE_W-1:0] size;
        logic [BASE_W-1:0] base;
    } win_cfg_t;

    // Build the read image of a control register.
    function automatic logic [DATA_W-1:0] ctrl_image(win_cfg_t c);
        return {8'h00, c.size, c.attr, 7'h00, c.en};
    endfunction

    // Build the read image of a base register.
    function automatic logic [DATA_W-1:0] base_image(win_cfg_t c);
        return {c.base, 16'h0000};
    endfunction

endpackage

// File: rtl/awd_regfile.sv
// Module: window register bank with write decode and combinational read mux.
// Assumes byte addressing. Slot = addr[REG_AW-1:3], addr[2] selects base (1)
// or control (0), and addr[1:0] is ignored. Slots >= NUM_WIN do not exist.
module awd_regfile
    import awd_pkg::*;
#(
    parameter int NUM_WIN = 8,
    parameter int REG_AW  = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_wr,
    input  logic [REG_AW-1:0]           reg_addr,
    input  logic [DATA_W-1:0]           reg_wdata,
    output logic [DATA_W-1:0]           reg_rdata,
    output win_cfg_t [NUM_WIN-1:0]      cfg_o
);

    localparam int SLOT_W = REG_AW - SLOT_LSB;

    logic [SLOT_W-1:0] slot;
    logic              sel_base;
    logic [1:0]        unused_lsb;

    assign slot       = reg_addr[REG_AW-1:SLOT_LSB];
    assign sel_base   = reg_addr[2];
    assign unused_lsb = reg_addr[1:0];

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        logic hit_slot;
        assign hit_slot = reg_wr && (slot == SLOT_W'(w));

        // Store one window's fields on a write to its slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_o[w] <= '0;
            end else if (hit_slot) begin
                if (sel_base) begin
                    cfg_o[w].base <= reg_wdata[31:16];
                end else begin
                    cfg_o[w].en   <= reg_wdata[0];
                    cfg_o[w].attr <= reg_wdata[15:8];
                    cfg_o[w].size <= reg_wdata[23:16];
                end
            end
        end
    end

    // Return the addressed register image, or zero for an absent slot.
    always_comb begin
        reg_rdata = '0;
        for (int w = 0; w < NUM_WIN; w++) begin
            if (slot == SLOT_W'(w)) begin
                reg_rdata = sel_base ? base_image(cfg_o[w]) : ctrl_image(cfg_o[w]);
            end
        end
    end

endmodule

// File: rtl/awd_match.sv
// Module: per-window masked compare of address bits 31:16 against each base.
// Assumes the size field marks the low-order don't-care bits of bits 23:16.
module awd_match
    import awd_pkg::*;
#(
    parameter int NUM_WIN = 8
) (
    input  logic [BASE_W-1:0]           addr_hi,
    input  win_cfg_t [NUM_WIN-1:0]      cfg_i,
    output logic [NUM_WIN-1:0]          hit_vec
);

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
        logic [BASE_W-1:0] care;
        // Compare only the address bits the size mask does not cover.
        always_comb begin
            care       = ~{{(BASE_W-SIZE_W){1'b0}}, cfg_i[w].size};
            hit_vec[w] = cfg_i[w].en && (((addr_hi ^ cfg_i[w].base) & care) == '0);
        end
    end

endmodule

// File: rtl/awd_select.sv
// Module: fixed-priority pick of the lowest-numbered matching window.
// Assumes hit_vec bit n belongs to window n.
module awd_select
    import awd_pkg::*;
#(
    parameter int NUM_WIN = 8
) (
    input  logic [NUM_WIN-1:0]          hit_vec,
    input  win_cfg_t [NUM_WIN-1:0]      cfg_i,
    output logic                        any_hit,
    output logic [ATTR_W-1:0]           attr
);

    // Scan from the highest window down so that the lowest one wins.
    always_comb begin
        any_hit = |hit_vec;
        attr    = '0;
        for (int w = NUM_WIN - 1; w >= 0; w--) begin
            if (hit_vec[w]) begin
                attr = cfg_i[w].attr;
            end
        end
    end

endmodule

// File: rtl/addr_window_decoder.sv
// Module: top of the programmable address window decoder.
// Decodes combinationally from txn_addr and registers hit, error and attribute.
// Assumes software enables a window only after its other fields are written.
module addr_window_decoder
    import awd_pkg::*;
#(
    parameter int NUM_WIN = 8,
    parameter int REG_AW  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic                txn_valid,
    input  logic [31:0]         txn_addr,
    output logic                dec_hit,
    output logic                dec_err,
    output logic [7:0]          dec_attr
);

    win_cfg_t [NUM_WIN-1:0] cfg;
    logic [NUM_WIN-1:0]     hit_vec;
    logic                   any_hit;
    logic [ATTR_W-1:0]      sel_attr;
    logic [15:0]            unused_addr_lo;

    assign unused_addr_lo = txn_addr[15:0];

    awd_regfile #(.NUM_WIN(NUM_WIN), .REG_AW(REG_AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cfg_o     (cfg)
    );

    awd_match #(.NUM_WIN(NUM_WIN)) u_match (
        .addr_hi (txn_addr[31:16]),
        .cfg_i   (cfg),
        .hit_vec (hit_vec)
    );

    awd_select #(.NUM_WIN(NUM_WIN)) u_sel (
        .hit_vec (hit_vec),
        .cfg_i   (cfg),
        .any_hit (any_hit),
        .attr    (sel_attr)
    );

    // Register the decode result for one cycle of latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_hit  <= 1'b0;
            dec_err  <= 1'b0;
            dec_attr <= '0;
        end else begin
            dec_hit  <= txn_valid && any_hit;
            dec_err  <= txn_valid && !any_hit;
            dec_attr <= (txn_valid && any_hit) ? sel_attr : '0;
        end
    end

endmodule

// File: rtl/awd_checker.sv
// Module: port-level properties of the address window decoder, bound to the top.
// Assumes it sees only the top ports.
module awd_checker #(
    parameter int REG_AW = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [REG_AW-1:0] reg_addr,
    input logic [31:0]       reg_rdata,
    input logic              txn_valid,
    input logic              dec_hit,
    input logic              dec_err,
    input logic [7:0]        dec_attr
);

    logic armed;

    // Mark that at least one clock edge has passed since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R7
    err_attr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_err |-> (dec_attr == 8'h00 && !dec_hit));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !$past(txn_valid)) |-> (!dec_hit && !dec_err && dec_attr == 8'h00));

    // R10
    valid_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(txn_valid)) |-> (dec_hit != dec_err));

    // R2
    ctrl_rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_addr[2] |-> (reg_rdata[7:1] == 7'h00 && reg_rdata[31:24] == 8'h00));

    // R3
    base_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_addr[2] |-> (reg_rdata[15:0] == 16'h0000));

endmodule

bind addr_window_decoder awd_checker #(.REG_AW(REG_AW)) u_awd_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .txn_valid (txn_valid),
    .dec_hit   (dec_hit),
    .dec_err   (dec_err),
    .dec_attr  (dec_attr)
);

// File: tb/addr_window_decoder_tb.sv
`timescale 1ns/1ps
module addr_window_decoder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        txn_valid = 1'b0;
    logic [31:0] txn_addr = '0;
    logic        dec_hit;
    logic        dec_err;
    logic [7:0]  dec_attr;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    addr_window_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .txn_valid(txn_valid),
        .txn_addr(txn_addr), .dec_hit(dec_hit), .dec_err(dec_err), .dec_attr(dec_attr)
    );

    // Vector layout: {expected hit, expected attr, address}
    localparam logic [40:0] VEC [11] = '{
        {1'b1, 8'h11, 32'h1000_0000},   // R4 start of 1 MB window 0
        {1'b1, 8'h11, 32'h100F_FFFC},   // R4 end of window 0
        {1'b1, 8'h22, 32'h1010_0000},   // R6 only window 1 covers this
        {1'b1, 8'h22, 32'h10FF_FFFF},   // R4 end of 16 MB window 1
        {1'b0, 8'h00, 32'h1100_0000},   // R7 just past window 1
        {1'b1, 8'h33, 32'h2000_FFFF},   // R4 64 KB window 2, last byte
        {1'b0, 8'h00, 32'h2001_0000},   // R7 just past window 2
        {1'b0, 8'h00, 32'h3000_0000},   // R5 window 3 disabled
        {1'b1, 8'h77, 32'hF03F_FFFF},   // R4 end of 4 MB window 7
        {1'b0, 8'h00, 32'hF040_0000},   // R7 just past window 7
        {1'b0, 8'h00, 32'h0000_0000}    // R7 unmapped
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // Present one address for one cycle, then return {err, hit, attr} seen after the edge.
    task automatic dec(logic [31:0] a, output logic [9:0] r);
        @(negedge clk);
        txn_valid = 1'b1; txn_addr = a;
        @(negedge clk);
        r = {dec_err, dec_hit, dec_attr};
        txn_valid = 1'b0;
    endtask

    // Expected {err, hit, attr} word for a hit or a miss.
    function automatic logic [31:0] exp_of(logic hit, logic [7:0] attr);
        return hit ? {22'd0, 2'b01, attr} : {22'd0, 2'b10, 8'h00};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R10 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [9:0]  r;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 outputs after reset", {21'd0, dec_hit, dec_err, dec_attr}, 32'h0);
        rst_n = 1'b1;
        rd(8'h00, d); check("R1 ctrl0 clear", d, 32'h0);
        rd(8'h3C, d); check("R1 base7 clear", d, 32'h0);

        // R2/R3 field read-back on slot 5 (byte offset 0x28 / 0x2C)
        wr(8'h28, 32'hFFFF_FFFF); rd(8'h28, d); check("R2 ctrl fields", d, 32'h00FF_FF01);
        wr(8'h2F, 32'hFFFF_FFFF); rd(8'h2C, d); check("R3 base field, addr[1:0] ignored", d, 32'hFFFF_0000);
        wr(8'h28, 32'h0); wr(8'h2C, 32'h0);

        // R9 absent slot 8 at 0x40: reads zero, cannot decode
        wr(8'h44, 32'h5000_0000); wr(8'h40, 32'h0000_9901);
        rd(8'h40, d); check("R9 absent ctrl reads zero", d, 32'h0);
        rd(8'h44, d); check("R9 absent base reads zero", d, 32'h0);
        dec(32'h5000_0000, r); check("R9 absent slot no decode", {22'd0, r}, exp_of(1'b0, 8'h00));

        // Program windows
        wr(8'h04, 32'h1000_0000); wr(8'h00, 32'h000F_1101);   // win0 1 MB attr 11
        wr(8'h0C, 32'h1000_0000); wr(8'h08, 32'h00FF_2201);   // win1 16 MB attr 22
        wr(8'h14, 32'h2000_0000); wr(8'h10, 32'h0000_3301);   // win2 64 KB attr 33
        wr(8'h1C, 32'h3000_0000); wr(8'h18, 32'h000F_4400);   // win3 disabled
        wr(8'h3C, 32'hF000_0000); wr(8'h38, 32'h003F_7701);   // win7 4 MB attr 77

        for (int i = 0; i < 11; i++) begin
            dec(VEC[i][31:0], r);
            check($sformatf("R4/R6/R7 vector %0d", i), {22'd0, r}, exp_of(VEC[i][40], VEC[i][39:32]));
        end

        // R5 write attribute and size with enable clear, then enable
        wr(8'h24, 32'h4000_0000); wr(8'h20, 32'h0000_5500);
        dec(32'h4000_0000, r); check("R5 disabled window no hit", {22'd0, r}, exp_of(1'b0, 8'h00));
        wr(8'h20, 32'h0000_5501);
        dec(32'h4000_0000, r); check("R5 R10 enable applies next edge", {22'd0, r}, exp_of(1'b1, 8'h55));

        // R10 output latency: before the edge the old value remains
        @(negedge clk);
        txn_valid = 1'b1; txn_addr = 32'h2000_0000;
        #1 check("R10 no change before edge", {22'd0, dec_err, dec_hit, dec_attr}, 32'h0);
        @(negedge clk);
        check("R10 result after edge", {22'd0, dec_err, dec_hit, dec_attr}, exp_of(1'b1, 8'h33));

        // R8 valid low silences outputs
        txn_valid = 1'b0; txn_addr = 32'h1000_0000;
        @(negedge clk);
        check("R8 idle outputs", {22'd0, dec_err, dec_hit, dec_attr}, 32'h0);

        // R1 reset mid-run clears windows
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(8'h00, d); check("R1 ctrl0 cleared by reset", d, 32'h0);
        dec(32'h1000_0000, r); check("R1 no hit after reset", {22'd0, r}, exp_of(1'b0, 8'h00));

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule